// File: doc/BRIEF.md
# Byte-Pointer Serial-Bus Memory Target

This block is a target on a two-wire serial bus (SMBus/I2C signalling) that serves a 256-byte array through one shared 8-bit access pointer. The bus lines enter through a two-flop synchronizer and are handled entirely in the system clock domain. SDA is driven only as an open-drain pull-down enable, and SCL is only observed.

A write transaction uses its first data byte to load the pointer and stores nothing for that byte. Each later data byte is written at the pointer, and the pointer then steps forward by one with wrap-around. A read transaction returns the byte at the pointer, most significant bit first, and advances the pointer once for every byte sent. The bus address is a fixed base of 0x50 plus a 3-bit instance index taken from a strap input, so eight copies can share one bus.

Reset reloads all 256 bytes from a wide parallel image input and clears the pointer. The array is captured on every clock edge while reset is low, so reset must be held for at least one clock.

Top module: `smbus_rom_target`

## Requirements
- R1: The target acknowledges a first frame byte whose upper seven bits equal 0x50 plus `addr_idx_i`; for any other address it drives nothing for the rest of the transaction. Bit 0 of that byte selects a read when 1 and a write when 0.
- R2: In a write, the first data byte loads the pointer and is not stored anywhere in the array.
- R3: Each later data byte in a write is stored at the pointer, after which the pointer increments modulo 256, so a byte written at 0xFF is followed by a byte written at 0x00.
- R4: A read returns the byte at the pointer, MSB first, and advances the pointer by one, wrapping from 0xFF to 0x00.
- R5: While `rst_ni` is low, `sda_drive_o` is 0, the pointer is 0, and byte i of the array takes the value `image_i[8*i+7:8*i]`.
- R6: After the controller NACKs a read byte, or after an address mismatch, the target keeps SDA released until the next START.
- R7: The target acknowledges every data byte of an addressed write.
- R8: A repeated START in the middle of a byte discards the partial byte and returns the target to address matching.
- R9: After a STOP, SCL pulses without a START cause no drive on SDA and no change to the array or the pointer.
- R10: Consecutive bytes in one read come from consecutive pointer values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the array reloads from the image while it is low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_o | output | 1 | Drive SDA low when 1; release when 0 |
| addr_idx_i | input | 3 | Instance index that is added to the 0x50 base address |
| image_i | input | 2048 | Initial array contents, byte i at bits 8*i+7 down to 8*i |

## Verification
A data-byte store and the pointer wrap fall in the same clock cycle. The pointer is first set to 0xFE, then three bytes are written so that the store at 0xFF and the pointer's return to 0x00 coincide. The result is judged by reading those three locations back and taking one more read, which must come from 0x01. The pointer load from the first data byte and a repeated START that cuts a byte short are also provoked. A behavioural model in the bench mirrors the array and the pointer, every read byte is compared against it, and every clock is watched for drive on SDA during windows that must stay released.

// File: rtl/smbus_rom_pkg.sv
package smbus_rom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_RNEXT
  } eng_st_e;
endpackage

// File: rtl/smbus_rom_sync.sv
module smbus_rom_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/smbus_rom_store.sv
module smbus_rom_store #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << PTR_W,
  localparam int IMG_W = DATA_W * DEPTH
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic [IMG_W-1:0]  image_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cells_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      for (int i = 0; i < DEPTH; i++) cells_q[i] <= image_i[i*DATA_W +: DATA_W];
    end else if (we_i) begin
      cells_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/smbus_rom_engine.sv
module smbus_rom_engine
  import smbus_rom_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int IDX_W  = 3,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [IDX_W-1:0]  addr_idx_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_drive_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              idle_o,
  output logic              start_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  eng_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, tx_q, wdata_q;
  logic [PTR_W-1:0]  ptr_q, waddr_q;
  logic              drive_q, first_q, we_q;
  logic              scl_p, sda_p;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]        my_addr;
  logic [BIT_W-1:0]  bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_p;
  assign scl_fall  = ~scl_i & scl_p;
  assign start_det = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_det  = scl_i & scl_p & ~sda_p & sda_i;
  assign my_addr   = BASE_ADDR + 7'(addr_idx_i);
  assign bit_idx   = BIT_W'(DATA_W - 1) - BIT_W'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      drive_q <= 1'b0;
      first_q <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        st_q    <= ST_ADDR;
        cnt_q   <= '0;
        drive_q <= 1'b0;
      end else if (stop_det) begin
        st_q    <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (sh_q[DATA_W-1 -: 7] == my_addr) begin
                drive_q <= 1'b1;
                st_q    <= ST_AACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (sh_q[0]) begin
                tx_q    <= rd_data_i;
                ptr_q   <= ptr_q + 1'b1;
                drive_q <= ~rd_data_i[DATA_W-1];
                st_q    <= ST_RD;
              end else begin
                drive_q <= 1'b0;
                first_q <= 1'b1;
                st_q    <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (first_q) begin
                ptr_q <= sh_q[PTR_W-1:0];
              end else begin
                we_q    <= 1'b1;
                waddr_q <= ptr_q;
                wdata_q <= sh_q;
                ptr_q   <= ptr_q + 1'b1;
              end
              first_q <= 1'b0;
              drive_q <= 1'b1;
              st_q    <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              cnt_q   <= '0;
              st_q    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) begin
                drive_q <= 1'b0;
                st_q    <= ST_RACK;
              end else begin
                drive_q <= ~tx_q[bit_idx];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) st_q <= sda_i ? ST_IDLE : ST_RNEXT;
          end
          ST_RNEXT: begin
            if (scl_fall) begin
              cnt_q   <= '0;
              tx_q    <= rd_data_i;
              ptr_q   <= ptr_q + 1'b1;
              drive_q <= ~rd_data_i[DATA_W-1];
              st_q    <= ST_RD;
            end
          end
          default: begin
            drive_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign sda_drive_o = drive_q;
  assign ptr_o       = ptr_q;
  assign we_o        = we_q;
  assign waddr_o     = waddr_q;
  assign wdata_o     = wdata_q;
  assign idle_o      = (st_q == ST_IDLE);
  assign start_o     = start_det;
endmodule

// File: rtl/smbus_rom_target.sv
module smbus_rom_target #(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int IDX_W  = 3,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << PTR_W,
  localparam int IMG_W = DATA_W * DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_drive_o,
  input  logic [IDX_W-1:0] addr_idx_i,
  input  logic [IMG_W-1:0] image_i
);
  logic [1:0]        line_s;
  logic [PTR_W-1:0]  ptr, mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              mem_we, eng_idle, eng_start;

  smbus_rom_sync #(.N(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  smbus_rom_engine #(
    .BASE_ADDR (BASE_ADDR),
    .IDX_W     (IDX_W),
    .PTR_W     (PTR_W),
    .DATA_W    (DATA_W)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (line_s[1]),
    .sda_i       (line_s[0]),
    .addr_idx_i  (addr_idx_i),
    .rd_data_i   (mem_rdata),
    .sda_drive_o (sda_drive_o),
    .ptr_o       (ptr),
    .we_o        (mem_we),
    .waddr_o     (mem_waddr),
    .wdata_o     (mem_wdata),
    .idle_o      (eng_idle),
    .start_o     (eng_start)
  );

  smbus_rom_store #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .load_i  (~rst_ni),
    .image_i (image_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (ptr),
    .rdata_o (mem_rdata)
  );
endmodule

// File: rtl/smbus_rom_chk.sv
module smbus_rom_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_drive_i,
  input logic             idle_i,
  input logic             start_i,
  input logic             we_i,
  input logic [PTR_W-1:0] waddr_i,
  input logic [PTR_W-1:0] ptr_i
);
  // R3: a store leaves the pointer one past the stored location
  a_r3_store_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ptr_i == PTR_W'(waddr_i + 1'b1));

  // R6: nothing is driven while waiting for a START
  a_r6_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_drive_i);

  // R8: a START releases the line on the following cycle
  a_r8_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_drive_i);

  // R5: pointer and drive are cleared during reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r5_reset_clear: assert (ptr_i == '0 && !sda_drive_i);
    end
  end
endmodule

bind smbus_rom_target smbus_rom_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_drive_i (sda_drive_o),
  .idle_i      (eng_idle),
  .start_i     (eng_start),
  .we_i        (mem_we),
  .waddr_i     (mem_waddr),
  .ptr_i       (ptr)
);

// File: tb/sim_smbus_rom_target.sv
module sim_smbus_rom_target;
  localparam int H = 16;
  localparam logic [2:0] IDX = 3'd2;
  localparam logic [7:0] ADDR_W = {7'h52, 1'b0};
  localparam logic [7:0] ADDR_R = {7'h52, 1'b1};
  localparam logic [7:0] ADDR_BAD = {7'h57, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive;
  logic sda_line;
  logic [2047:0] image;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] ref_mem [256];
  int ref_ptr = 0;
  logic [7:0] wq [$];
  bit quiet = 1'b0;
  bit saw = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive;

  smbus_rom_target u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_drive_o (sda_drive),
    .addr_idx_i  (IDX),
    .image_i     (image)
  );

  // every clock: watch windows in which SDA must stay released
  always @(negedge clk) if (quiet && sda_drive) saw <= 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(H);
    scl = 1'b1;   hold(H);
    sda_m = 1'b0; hold(H);
    scl = 1'b0;   hold(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(H);
    scl = 1'b1;   hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;  hold(H);
    scl = 1'b1; hold(H);
    scl = 1'b0; hold(H);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hold(H);
    scl = 1'b1;   hold(H / 2);
    b = sda_line; hold(H / 2);
    scl = 1'b0;   hold(H);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic do_reset(input bit alt);
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = alt ? (8'(i) ^ 8'h5A) : 8'((i * 37 + 11) & 255);
      image[i*8 +: 8] = ref_mem[i];
    end
    rst_ni = 1'b0;
    hold(4);
    chk(sda_drive == 1'b0, "R5 drive in reset", int'(sda_drive), 0);
    ref_ptr = 0;
    rst_ni = 1'b1;
    hold(4);
  endtask

  // first data byte p sets pointer, then wq is stored
  task automatic do_write(input logic [7:0] p);
    logic a;
    bus_start();
    wr_byte(ADDR_W, a);
    chk(a, "R1 addr ack", int'(a), 1);
    wr_byte(p, a);
    chk(a, "R7 ptr byte ack", int'(a), 1);
    ref_ptr = p;
    foreach (wq[i]) begin
      wr_byte(wq[i], a);
      chk(a, "R7 data ack", int'(a), 1);
      ref_mem[ref_ptr] = wq[i];
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic do_read(input int n, input string tag);
    logic a;
    logic [7:0] v;
    bus_start();
    wr_byte(ADDR_R, a);
    chk(a, "R1 read addr ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(v, k != n - 1);
      chk(v == ref_mem[ref_ptr], tag, int'(v), int'(ref_mem[ref_ptr]));
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    image = '0;
    #1;
    do_reset(1'b0);

    // R5 R4 R10: reads start at 0 with image contents
    do_read(3, "R5 R10 image read");

    // R2 R7: write pointer byte only, then data
    wq = {};
    do_write(8'h10);
    wq = {8'h11, 8'h22, 8'h33};
    do_write(8'h10);
    wq = {};
    do_write(8'h10);
    do_read(3, "R3 stored data");
    wq = {};
    do_write(8'h03);
    do_read(1, "R2 ptr byte not stored");

    // R3: store at 0xFF coincides with pointer wrap
    wq = {8'hA1, 8'hB2, 8'hC3};
    do_write(8'hFE);
    do_read(1, "R3 ptr after wrap");
    wq = {};
    do_write(8'hFE);
    do_read(3, "R3 wrap store");

    // R4: read wraps 0xFF -> 0x00
    do_write(8'hFF);
    do_read(2, "R4 read wrap");

    // R1 R6: wrong address stays released
    saw = 1'b0;
    quiet = 1'b1;
    bus_start();
    wr_byte(ADDR_BAD, a);
    chk(!a, "R1 mismatch nack", int'(a), 0);
    wr_byte(8'h00, a);
    wr_byte(8'h99, a);
    bus_stop();
    quiet = 1'b0;
    chk(saw == 1'b0, "R6 mismatch released", int'(saw), 0);
    do_read(1, "R1 mismatch no effect");

    // R8: repeated START mid-byte
    bus_start();
    wr_byte(ADDR_W, a);
    wr_byte(8'h40, a);
    ref_ptr = 8'h40;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    wr_byte(ADDR_R, a);
    chk(a, "R8 addr after rstart", int'(a), 1);
    rd_byte(v, 1'b0);
    chk(v == ref_mem[8'h40], "R8 partial discarded", int'(v), int'(ref_mem[8'h40]));
    ref_ptr = 8'h41;

    // R6: after NACK no drive before STOP
    saw = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) put_bit(1'b1);
    quiet = 1'b0;
    chk(saw == 1'b0, "R6 released after nack", int'(saw), 0);
    bus_stop();

    // R9: SCL pulses after STOP without START
    saw = 1'b0;
    quiet = 1'b1;
    scl = 1'b0;
    hold(H);
    for (int i = 0; i < 18; i++) put_bit(i[0]);
    sda_m = 1'b1;
    hold(H);
    scl = 1'b1;
    hold(H);
    quiet = 1'b0;
    chk(saw == 1'b0, "R9 no drive after stop", int'(saw), 0);
    do_read(2, "R9 state kept");

    // R5: second image reloads altered bytes
    do_reset(1'b1);
    do_read(2, "R5 reload ptr zero");
    wq = {};
    do_write(8'h10);
    do_read(1, "R5 reload 0x10");
    do_write(8'hFF);
    do_read(1, "R5 reload 0xFF");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule